// File: doc/BRIEF.md
# DSI Video-Mode Timing Generator

This block turns a received DSI high-speed byte stream in video mode back into display timing strobes: horizontal sync, vertical sync, data enable and a pixel-clock enable. One byte arrives per byte-clock cycle with a valid flag and a start-of-transmission marker. A small parser reads each 4-byte packet header in the order data type, word count low byte, word count high byte, ECC. It acts on sync-start headers, on the packed 24-bit RGB long packet and on blanking packets. It skips the payload and the 2-byte checksum of every long packet.

The sync edges and the active-window edges are placed with byte accuracy from the cycle in which the ECC byte of a header arrives. A mode input selects how the start of the active window is placed. In non-burst mode with sync events, the start is delayed into the payload, so the window is exactly as long as the payload. In burst mode the window opens on the first payload byte. The width of the Hsync pulse and the length of the Vsync pulse in lines are set by configuration inputs. The pixel-clock enable follows the RGB payload, and between payloads it is kept running by a programmable divider.

Parser states: `P_IDLE` (waits for a valid byte flagged as start of transmission), `P_HDR` (collects the four header bytes), `P_PAY` (skips word count plus two bytes of a long packet). Transitions: `P_IDLE`→`P_HDR` on a valid byte with the start marker. `P_HDR`→`P_PAY` on the ECC byte of a long header. `P_PAY`→`P_HDR` on the last checksum byte. Any state→`P_HDR` on a valid byte with the start marker. `P_HDR`/`P_PAY`→`P_IDLE` when the valid flag drops.

Top module: `dsi_vid_timing`

## Requirements
- R1: A synchronous active-high reset clears hsync, vsync, de and pix_en in the cycle after it is sampled, and puts the parser back into waiting for a start marker.
- R2: hsync rises in the cycle after the ECC byte (header byte 3) of a header whose type byte (header byte 0) is 0x21 is accepted. Header byte 0 is the valid byte that carries the start marker while idle, or the byte that follows a completed packet.
- R3: hsync stays high for exactly hs_width byte cycles; a hs_width of 0 is treated as 1.
- R4: A header of type 0x01 raises vsync and hsync in the cycle after its ECC byte. vsync falls in the cycle after the ECC byte of the vs_lines-th type-0x21 header that follows (0 treated as 1).
- R5: de falls in the cycle after the ECC byte of any header whose type is not 0x3E.
- R6: With burst_mode=0, de rises in the cycle after the sixth payload byte (index 5) of a type-0x3E packet. When a blanking header directly follows the checksum, de is then high for exactly word-count cycles.
- R7: With burst_mode=1, de rises in the cycle after the first payload byte (index 0) of a type-0x3E packet.
- R8: During the word-count data bytes of a type-0x3E packet, pix_en is high in the cycle after payload byte j exactly when j mod 3 = 2.
- R9: Outside RGB payload, pix_en pulses once every pclk_div+1 byte cycles.
- R10: Long packets (types 0x3E and 0x19) take their word count from header bytes 1 (low) and 2 (high). Their payload and checksum bytes are never read as headers.
- R11: A valid byte without the start marker while idle is ignored, and a drop of byte_vld returns the parser to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | byte_data holds a received byte |
| byte_sot | input | 1 | This byte is the first after start of transmission |
| byte_data | input | 8 | Received byte |
| burst_mode | input | 1 | 1 selects burst mode, 0 non-burst with sync events |
| hs_width | input | HSW_W | Hsync pulse width in byte cycles |
| vs_lines | input | VSL_W | Vsync length in lines |
| pclk_div | input | DIV_W | Pixel-enable period minus one outside payload |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable (active window) |
| pix_en | output | 1 | Pixel-clock enable |

## Verification
The assertions assume that the configuration inputs stay constant while a stream is in flight. They also assume that two sync-start headers are never closer together than hs_width cycles, so an Hsync pulse is never retriggered while it is still high. They further assume that every header starts on a byte that carries the start marker or directly follows a complete packet. The stimulus changes configuration only while byte_vld is low, keeps at least two idle cycles between streams, and uses word counts of at least six in non-burst mode. It also fills all payload bytes with the horizontal-sync type code, so that any misread payload would show up at the outputs.

// File: rtl/dsi_vtg_pkg.sv
package dsi_vtg_pkg;
    localparam int WC_W = 16;

    localparam logic [7:0] DT_VSS  = 8'h01;
    localparam logic [7:0] DT_HSS  = 8'h21;
    localparam logic [7:0] DT_BLNK = 8'h19;
    localparam logic [7:0] DT_RGB  = 8'h3E;

    typedef enum logic [1:0] {
        P_IDLE,
        P_HDR,
        P_PAY
    } prs_state_t;

    typedef struct packed {
        logic hss;      // ECC of horizontal sync start header
        logic vss;      // ECC of vertical sync start header
        logic end_act;  // ECC of any non-RGB header
        logic rgb_hdr;  // ECC of an RGB long header
        logic pay;      // RGB data byte (checksum excluded)
        logic de_go;    // payload byte that opens the active window
    } vtg_evt_t;
endpackage

// File: rtl/dsi_vtg_parser.sv
module dsi_vtg_parser
    import dsi_vtg_pkg::*;
#(
    parameter int NB_DLY = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_vld,
    input  logic       byte_sot,
    input  logic [7:0] byte_data,
    input  logic       burst_mode,
    output vtg_evt_t   evt
);
    localparam int LEN_W = WC_W + 1;

    prs_state_t       st_q;
    logic [1:0]       hcnt_q;
    logic [7:0]       dt_q;
    logic [WC_W-1:0]  wc_q;
    logic [LEN_W-1:0] idx_q;
    logic [LEN_W-1:0] len_q;
    logic             rgb_q;
    logic             take;
    logic             is_long;
    logic             hdr_ecc;

    assign take    = byte_vld && !byte_sot;
    assign is_long = (dt_q == DT_RGB) || (dt_q == DT_BLNK);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= P_IDLE;
            hcnt_q <= '0;
            dt_q   <= '0;
            wc_q   <= '0;
            idx_q  <= '0;
            len_q  <= '0;
            rgb_q  <= 1'b0;
        end else if (byte_vld && byte_sot) begin
            st_q   <= P_HDR;
            hcnt_q <= 2'd1;
            dt_q   <= byte_data;
        end else if (!byte_vld) begin
            st_q   <= P_IDLE;
        end else begin
            unique case (st_q)
                P_IDLE: begin
                    st_q <= P_IDLE;
                end
                P_HDR: begin
                    hcnt_q <= hcnt_q + 2'd1;
                    unique case (hcnt_q)
                        2'd0: dt_q <= byte_data;
                        2'd1: wc_q[7:0] <= byte_data;
                        2'd2: wc_q[15:8] <= byte_data;
                        2'd3: begin
                            if (is_long) begin
                                st_q  <= P_PAY;
                                len_q <= LEN_W'(wc_q) + LEN_W'(2);
                                idx_q <= '0;
                                rgb_q <= (dt_q == DT_RGB);
                            end
                        end
                    endcase
                end
                P_PAY: begin
                    idx_q <= idx_q + LEN_W'(1);
                    if (idx_q == len_q - LEN_W'(1)) begin
                        st_q   <= P_HDR;
                        hcnt_q <= 2'd0;
                    end
                end
                default: st_q <= P_IDLE;
            endcase
        end
    end

    // event outputs
    always_comb begin
        hdr_ecc     = take && (st_q == P_HDR) && (hcnt_q == 2'd3);
        evt.hss     = hdr_ecc && (dt_q == DT_HSS);
        evt.vss     = hdr_ecc && (dt_q == DT_VSS);
        evt.end_act = hdr_ecc && (dt_q != DT_RGB);
        evt.rgb_hdr = hdr_ecc && (dt_q == DT_RGB);
        evt.pay     = take && (st_q == P_PAY) && rgb_q && (idx_q < LEN_W'(wc_q));
        evt.de_go   = evt.pay && (idx_q == (burst_mode ? LEN_W'(0) : LEN_W'(NB_DLY)));
    end
endmodule

// File: rtl/dsi_vtg_sync.sv
module dsi_vtg_sync #(
    parameter int HSW_W = 8,
    parameter int VSL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_hss,
    input  logic             ev_vss,
    input  logic [HSW_W-1:0] hs_width,
    input  logic [VSL_W-1:0] vs_lines,
    output logic             hsync,
    output logic             vsync
);
    logic [HSW_W-1:0] hcnt_q;
    logic [VSL_W-1:0] vcnt_q;
    logic [HSW_W-1:0] hw_eff;
    logic [VSL_W-1:0] vl_eff;

    always_comb begin
        hw_eff = (hs_width == '0) ? HSW_W'(1) : hs_width;
        vl_eff = (vs_lines == '0) ? VSL_W'(1) : vs_lines;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync  <= 1'b0;
            vsync  <= 1'b0;
            hcnt_q <= '0;
            vcnt_q <= '0;
        end else begin
            if (ev_hss || ev_vss) begin
                hsync  <= 1'b1;
                hcnt_q <= hw_eff;
            end else if (hsync) begin
                hcnt_q <= hcnt_q - HSW_W'(1);
                if (hcnt_q == HSW_W'(1)) hsync <= 1'b0;
            end
            if (ev_vss) begin
                vsync  <= 1'b1;
                vcnt_q <= vl_eff;
            end else if (ev_hss && vsync) begin
                vcnt_q <= vcnt_q - VSL_W'(1);
                if (vcnt_q == VSL_W'(1)) vsync <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dsi_vtg_pix.sv
module dsi_vtg_pix #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_rgb_hdr,
    input  logic             ev_pay,
    input  logic [DIV_W-1:0] pclk_div,
    output logic             pix_en
);
    logic [1:0]       ph_q;
    logic [DIV_W-1:0] dcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            dcnt_q <= '0;
            pix_en <= 1'b0;
        end else if (ev_pay) begin
            ph_q   <= (ph_q == 2'd2) ? 2'd0 : ph_q + 2'd1;
            pix_en <= (ph_q == 2'd2);
            dcnt_q <= '0;
        end else begin
            if (ev_rgb_hdr) ph_q <= '0;
            if (dcnt_q >= pclk_div) begin
                dcnt_q <= '0;
                pix_en <= 1'b1;
            end else begin
                dcnt_q <= dcnt_q + DIV_W'(1);
                pix_en <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dsi_vid_timing.sv
module dsi_vid_timing
    import dsi_vtg_pkg::*;
#(
    parameter int HSW_W  = 8,
    parameter int VSL_W  = 8,
    parameter int DIV_W  = 4,
    parameter int NB_DLY = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_vld,
    input  logic             byte_sot,
    input  logic [7:0]       byte_data,
    input  logic             burst_mode,
    input  logic [HSW_W-1:0] hs_width,
    input  logic [VSL_W-1:0] vs_lines,
    input  logic [DIV_W-1:0] pclk_div,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             pix_en
);
    vtg_evt_t evt;

    dsi_vtg_parser #(.NB_DLY(NB_DLY)) u_prs (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_sot(byte_sot),
        .byte_data(byte_data), .burst_mode(burst_mode), .evt(evt)
    );

    dsi_vtg_sync #(.HSW_W(HSW_W), .VSL_W(VSL_W)) u_sync (
        .clk(clk), .rst(rst), .ev_hss(evt.hss), .ev_vss(evt.vss),
        .hs_width(hs_width), .vs_lines(vs_lines), .hsync(hsync), .vsync(vsync)
    );

    dsi_vtg_pix #(.DIV_W(DIV_W)) u_pix (
        .clk(clk), .rst(rst), .ev_rgb_hdr(evt.rgb_hdr), .ev_pay(evt.pay),
        .pclk_div(pclk_div), .pix_en(pix_en)
    );

    always_ff @(posedge clk) begin
        if (rst)              de <= 1'b0;
        else if (evt.end_act) de <= 1'b0;
        else if (evt.de_go)   de <= 1'b1;
    end
endmodule

// File: rtl/dsi_vtg_chk.sv
module dsi_vtg_chk #(
    parameter int HSW_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             byte_vld,
    input logic [HSW_W-1:0] hs_width,
    input logic             hsync,
    input logic             vsync,
    input logic             de,
    input logic             pix_en
);
    logic             rst_q;
    logic [HSW_W:0]   hs_run_q;
    logic [HSW_W:0]   hw_lim;

    assign hw_lim = (hs_width == '0) ? (HSW_W+1)'(1) : {1'b0, hs_width};

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)        hs_run_q <= '0;
        else if (hsync) hs_run_q <= hs_run_q + (HSW_W+1)'(1);
        else            hs_run_q <= '0;
    end

    // R1: outputs are clear in the cycle after reset is sampled
    always @(posedge clk) begin
        if (rst_q) begin
            a_r1_reset_clear: assert (!hsync && !vsync && !de && !pix_en)
                else $error("a_r1_reset_clear");
        end
    end

    a_r2_hs_rise_on_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync) |-> $past(byte_vld));

    a_r3_hs_width_bound: assert property (@(posedge clk) disable iff (rst)
        hsync |-> (hs_run_q < hw_lim));

    a_r4_vs_with_hs: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync) |-> hsync);

    a_r5_de_fall_on_byte: assert property (@(posedge clk) disable iff (rst)
        $fell(de) |-> $past(byte_vld));

    a_r7_de_rise_on_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(de) |-> $past(byte_vld));
endmodule

bind dsi_vid_timing dsi_vtg_chk #(.HSW_W(HSW_W)) u_chk (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .hs_width(hs_width),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_en(pix_en)
);

// File: tb/tb_dsi_vid_timing.sv
module tb_dsi_vid_timing;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_vld = 1'b0;
    logic       byte_sot = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       burst_mode = 1'b0;
    logic [7:0] hs_width = 8'd2;
    logic [7:0] vs_lines = 8'd1;
    logic [3:0] pclk_div = 4'd0;
    logic       hsync, vsync, de, pix_en;

    always #2 clk = ~clk;

    dsi_vid_timing dut (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_sot(byte_sot),
        .byte_data(byte_data), .burst_mode(burst_mode), .hs_width(hs_width),
        .vs_lines(vs_lines), .pclk_div(pclk_div), .hsync(hsync), .vsync(vsync),
        .de(de), .pix_en(pix_en)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;
    int nb = 0;
    logic hs_a [0:79];
    logic vs_a [0:79];
    logic de_a [0:79];
    logic pe_a [0:79];

    // {burst, word count, hs_width, pclk_div}
    localparam logic [20:0] VEC [0:5] = '{
        {1'b0, 8'd12, 8'd3, 4'd2},
        {1'b1, 8'd12, 8'd3, 4'd2},
        {1'b0, 8'd9,  8'd0, 4'd0},
        {1'b1, 8'd7,  8'd5, 4'd4},
        {1'b0, 8'd6,  8'd8, 4'd1},
        {1'b1, 8'd30, 8'd2, 4'd3}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // outputs seen at a negedge belong to the byte driven one cycle earlier
    task automatic drive(input logic [7:0] b, input logic s);
        @(negedge clk);
        if (nb > 0) begin
            hs_a[nb-1] = hsync; vs_a[nb-1] = vsync;
            de_a[nb-1] = de;    pe_a[nb-1] = pix_en;
        end
        byte_data = b; byte_sot = s; byte_vld = 1'b1;
        nb++;
    endtask

    task automatic end_stream();
        @(negedge clk);
        if (nb > 0) begin
            hs_a[nb-1] = hsync; vs_a[nb-1] = vsync;
            de_a[nb-1] = de;    pe_a[nb-1] = pix_en;
        end
        byte_vld = 1'b0; byte_sot = 1'b0; byte_data = 8'h00;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_hdr(input logic [7:0] dt, input int wc, input logic s);
        drive(dt, s);
        drive(8'(wc), 1'b0);
        drive(8'(wc >> 8), 1'b0);
        drive(8'h00, 1'b0);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!hsync && !vsync && !de && !pix_en, "R1 reset outputs", int'({hsync, vsync, de, pix_en}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // vector table: one line per entry
        for (int k = 0; k < 6; k++) begin
            int bm, wc, hw, we, st, e, cnt, miss;
            bm = int'(VEC[k][20]); wc = int'(VEC[k][19:12]);
            hw = int'(VEC[k][11:4]);
            burst_mode = VEC[k][20]; hs_width = VEC[k][11:4]; pclk_div = VEC[k][3:0];
            we = (hw == 0) ? 1 : hw;
            nb = 0;
            send_hdr(8'h21, 0, 1'b1);
            send_hdr(8'h3E, wc, 1'b0);
            for (int j = 0; j < wc + 2; j++) drive(8'h21, 1'b0);
            send_hdr(8'h19, 0, 1'b0);
            drive(8'h21, 1'b0); drive(8'h21, 1'b0);
            end_stream();

            chk(!hs_a[2] && hs_a[3], "R2 hsync after ECC", int'(hs_a[3]), 1);
            cnt = 0;
            for (int i = 0; i < nb; i++) cnt += int'(hs_a[i]);
            chk(hs_a[3 + we - 1] && !hs_a[3 + we], "R3 hsync width", cnt, we);
            chk(cnt == we, "R10 payload not parsed as header", cnt, we);
            st = bm ? 8 : 13;
            chk(!de_a[st - 1] && de_a[st], bm ? "R7 burst de rise" : "R6 nonburst de rise", int'(de_a[st]), 1);
            e = wc + 13;
            chk(de_a[e - 1] && !de_a[e], "R5 de fall on blanking ECC", int'(de_a[e]), 0);
            cnt = 0;
            for (int i = 0; i < nb; i++) cnt += int'(de_a[i]);
            if (bm == 0) chk(cnt == wc, "R6 de length", cnt, wc);
            else         chk(cnt == wc + 5, "R7 de length", cnt, wc + 5);
            miss = 0;
            for (int j = 0; j < wc; j++) if (pe_a[8 + j] != ((j % 3) == 2)) miss++;
            chk(miss == 0, "R8 pix_en in payload", miss, 0);
        end

        // R4: vertical sync over two lines
        hs_width = 8'd2; vs_lines = 8'd2;
        nb = 0; send_hdr(8'h01, 0, 1'b1); end_stream();
        chk(!vs_a[2] && vs_a[3] && hs_a[3], "R4 vsync rise with hsync", int'({vs_a[3], hs_a[3]}), 3);
        nb = 0; send_hdr(8'h21, 0, 1'b1); end_stream();
        chk(vs_a[3], "R4 vsync held first line", int'(vs_a[3]), 1);
        nb = 0; send_hdr(8'h21, 0, 1'b1); end_stream();
        chk(vs_a[2] && !vs_a[3], "R4 vsync fall", int'(vs_a[3]), 0);

        // R9: divider outside payload
        for (int d = 0; d < 2; d++) begin
            int p0, p1, exp;
            pclk_div = d ? 4'd3 : 4'd0;
            exp = d ? 4 : 1;
            repeat (5) @(negedge clk);
            p0 = -1; p1 = -1;
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                if (pix_en) begin
                    if (p0 < 0) p0 = i;
                    else if (p1 < 0) p1 = i;
                end
            end
            chk(p0 >= 0 && (p1 - p0) == exp, "R9 divider period", p1 - p0, exp);
        end

        // R1: reset in mid pulse, then parser needs a start marker (R11)
        hs_width = 8'd8;
        nb = 0; send_hdr(8'h21, 0, 1'b1); end_stream();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk(!hsync && !vsync && !de && !pix_en, "R1 reset mid pulse", int'({hsync, vsync, de, pix_en}), 0);
        rst = 1'b0;
        nb = 0; send_hdr(8'h21, 0, 1'b0); end_stream();
        begin
            int c = 0;
            for (int i = 0; i < 4; i++) c += int'(hs_a[i]);
            chk(c == 0, "R11 no start marker ignored", c, 0);
        end

        // R11: valid drop returns to idle
        nb = 0; drive(8'h21, 1'b1); drive(8'h00, 1'b0); end_stream();
        nb = 0; drive(8'h00, 1'b0); drive(8'h00, 1'b0); end_stream();
        chk(!hs_a[0] && !hs_a[1] && !hsync, "R11 valid drop resets parser", int'(hs_a[1]), 0);
        nb = 0; send_hdr(8'h21, 0, 1'b1); end_stream();
        chk(hs_a[3], "R2 hsync after restart", int'(hs_a[3]), 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule